// File: doc/BRIEF.md
# Pedestrian Crossing Light Controller

This block sequences the lamps of a single pedestrian crossing. Vehicle traffic sees a green, yellow or red lamp, and pedestrians see a WALK or HALT indicator. The controller is a four-state Moore machine. It rests in the vehicle-green state until a pedestrian request arrives. It then runs once through yellow, red with WALK, and red with HALT, and returns to green.

The request input comes from a push button and has no timing relation to the clock. It passes through a two-stage synchronizer before the state logic sees it. Each state is held for its own parameterized number of clock cycles, called the dwell. The next state comes from two equations on the 2-bit state code, and those equations take effect only when the dwell has run out. The lamp and walk outputs are flip-flop outputs, and they always match the current state in the same cycle. A request is never stored: it has an effect only if its synchronized copy is high while the controller is in green and the green dwell has expired.

Top module: `xing_ctrl_top`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the controller enters the green state. In the cycle after that edge, `lamp` is 2'b00 (green) and `walkOn` is 0 (HALT).
- R2: The outputs decode the state as follows. `lamp` uses 2'b00 for green, 2'b01 for yellow and 2'b10 for red. `walkOn` uses 1 for WALK and 0 for HALT. Green shows HALT, yellow shows HALT, the crossing state shows red with WALK, and the clearance state shows red with HALT.
- R3: While the request input stays low, the controller stays green for any number of cycles.
- R4: Green lasts at least DWELL_S0 cycles. With the request held high from reset onward, yellow first appears exactly DWELL_S0 rising edges after reset is released.
- R5: The controller leaves yellow for red with WALK, leaves that state for red with HALT, and then returns to green. These three steps happen whatever the request input does.
- R6: A request that is high only while the controller is outside green is not stored. Once the request is low again, the controller returns to green and stays there.
- R7: Yellow lasts exactly DWELL_S1 cycles, red with WALK exactly DWELL_S2 cycles, and red with HALT exactly DWELL_S3 cycles.
- R8: `lamp` never takes the value 2'b11, and `walkOn` is 1 only while `lamp` is red.
- R9: Suppose the green dwell has expired and the request is high at exactly one rising edge. Then yellow appears in the cycle after the third rising edge, counted from the first edge at which the request was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| walkReqAsync | input | 1 | Pedestrian request from the button; not related to the clock |
| lamp | output | 2 | Vehicle lamp: 00 green, 01 yellow, 10 red |
| walkOn | output | 1 | Pedestrian indicator: 1 WALK, 0 HALT |

## Verification
The assertions work only on the output pins. They rely on the outputs being driven from flip-flops that reset to green. They also rely on the yellow dwell, DWELL_S1, being the value the checker was bound with.

The request input is driven once per cycle at the falling clock edge, so it is stable at every rising edge. Its metastability is therefore never exercised; the bench checks only the two-edge delay of the synchronizer.

The random phase switches between sparse and dense requests and adds occasional resets. Requests therefore fall both inside and outside green, and some arrive before the green dwell has expired.

// File: rtl/xing_ctrl_pkg.sv
package xing_ctrl_pkg;

  // State codes; the next-state equations depend on these exact values.
  typedef enum logic [1:0] {
    ST_GO    = 2'b00,
    ST_SLOW  = 2'b01,
    ST_CROSS = 2'b10,
    ST_CLEAR = 2'b11
  } xingState_t;

  localparam logic [1:0] LAMP_GREEN  = 2'b00;
  localparam logic [1:0] LAMP_YELLOW = 2'b01;
  localparam logic [1:0] LAMP_RED    = 2'b10;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    xingState_t cur;
    xingState_t nxt;
    logic       restart;
  } xingCtl_t;

endpackage

// File: rtl/xing_sync.sv
module xing_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/xing_ctrl_fsm.sv
module xing_ctrl_fsm
  import xing_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     walkReq,
  input  logic     dwellDone,
  output xingCtl_t ctl
);

  xingState_t stateQ;
  xingState_t stateD;
  logic       q1, q2, d1, d2;

  assign q1 = stateQ[1];
  assign q2 = stateQ[0];

  // Next-state equations on the 2-bit state code.
  always_comb begin
    d1 = q1 ^ q2;
    d2 = ~q2 & (q1 | walkReq);
    if (dwellDone) stateD = xingState_t'({d1, d2});
    else           stateD = stateQ;
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_GO;
    else     stateQ <= stateD;
  end

  always_comb begin
    ctl.cur     = stateQ;
    ctl.nxt     = stateD;
    ctl.restart = (stateD != stateQ);
  end

endmodule

// File: rtl/xing_ctrl_dp.sv
module xing_ctrl_dp
  import xing_ctrl_pkg::*;
#(
  parameter int DWELL_S0 = 4,
  parameter int DWELL_S1 = 2,
  parameter int DWELL_S2 = 6,
  parameter int DWELL_S3 = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  xingCtl_t   ctl,
  output logic       dwellDone,
  output logic [1:0] lamp,
  output logic       walkOn
);

  localparam int MAX01  = (DWELL_S0 > DWELL_S1) ? DWELL_S0 : DWELL_S1;
  localparam int MAX23  = (DWELL_S2 > DWELL_S3) ? DWELL_S2 : DWELL_S3;
  localparam int MAXD   = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNT_W  = $clog2(MAXD + 1);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] lastTick;
  logic [1:0]       lampQ;
  logic             walkQ;

  always_comb begin
    case (ctl.cur)
      ST_GO:    lastTick = CNT_W'(DWELL_S0 - 1);
      ST_SLOW:  lastTick = CNT_W'(DWELL_S1 - 1);
      ST_CROSS: lastTick = CNT_W'(DWELL_S2 - 1);
      default:  lastTick = CNT_W'(DWELL_S3 - 1);
    endcase
  end

  assign dwellDone = (cntQ == lastTick);

  // Dwell counter: cleared on each state change, held once the dwell is reached.
  always_ff @(posedge clk) begin
    if (rst || ctl.restart) cntQ <= '0;
    else if (!dwellDone)    cntQ <= cntQ + 1'b1;
  end

  // Outputs are registered from the next state, so they line up with the state.
  always_ff @(posedge clk) begin
    if (rst) begin
      lampQ <= LAMP_GREEN;
      walkQ <= 1'b0;
    end else begin
      case (ctl.nxt)
        ST_GO:    begin lampQ <= LAMP_GREEN;  walkQ <= 1'b0; end
        ST_SLOW:  begin lampQ <= LAMP_YELLOW; walkQ <= 1'b0; end
        ST_CROSS: begin lampQ <= LAMP_RED;    walkQ <= 1'b1; end
        default:  begin lampQ <= LAMP_RED;    walkQ <= 1'b0; end
      endcase
    end
  end

  assign lamp   = lampQ;
  assign walkOn = walkQ;

endmodule

// File: rtl/xing_ctrl_top.sv
module xing_ctrl_top
  import xing_ctrl_pkg::*;
#(
  parameter int DWELL_S0    = 4,
  parameter int DWELL_S1    = 2,
  parameter int DWELL_S2    = 6,
  parameter int DWELL_S3    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       walkReqAsync,
  output logic [1:0] lamp,
  output logic       walkOn
);

  logic     walkReq;
  logic     dwellDone;
  xingCtl_t ctl;

  xing_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(walkReqAsync),
    .syncOut(walkReq)
  );

  xing_ctrl_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .walkReq  (walkReq),
    .dwellDone(dwellDone),
    .ctl      (ctl)
  );

  xing_ctrl_dp #(
    .DWELL_S0(DWELL_S0),
    .DWELL_S1(DWELL_S1),
    .DWELL_S2(DWELL_S2),
    .DWELL_S3(DWELL_S3)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .dwellDone(dwellDone),
    .lamp     (lamp),
    .walkOn   (walkOn)
  );

endmodule

// File: rtl/xing_ctrl_chk.sv
module xing_ctrl_chk #(
  parameter int DWELL_S1 = 2
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] lamp,
  input logic       walkOn
);

  logic       pastValid;
  logic [7:0] yellowRun;

  always_ff @(posedge clk) begin
    if (rst) pastValid <= 1'b0;
    else     pastValid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 yellowRun <= '0;
    else if (lamp == 2'b01)  yellowRun <= yellowRun + 1'b1;
    else                     yellowRun <= '0;
  end

  AST_LAMP_LEGAL: assert property (@(posedge clk) disable iff (rst || !pastValid)
    lamp != 2'b11); // R8

  AST_WALK_ONLY_RED: assert property (@(posedge clk) disable iff (rst || !pastValid)
    walkOn |-> (lamp == 2'b10)); // R8

  AST_YELLOW_FROM_GREEN: assert property (@(posedge clk) disable iff (rst || !pastValid)
    (lamp == 2'b01 && $past(lamp) != 2'b01) |-> ($past(lamp) == 2'b00)); // R5

  AST_GREEN_FROM_CLEAR: assert property (@(posedge clk) disable iff (rst || !pastValid)
    (lamp == 2'b00 && $past(lamp) != 2'b00) |-> ($past(lamp) == 2'b10 && !$past(walkOn))); // R5

  AST_WALK_ENDS_TO_HALT: assert property (@(posedge clk) disable iff (rst || !pastValid)
    $fell(walkOn) |-> (lamp == 2'b10)); // R5

  AST_YELLOW_DWELL: assert property (@(posedge clk) disable iff (rst || !pastValid)
    (lamp != 2'b01 && $past(lamp) == 2'b01) |-> (yellowRun == 8'(DWELL_S1))); // R7

endmodule

bind xing_ctrl_top xing_ctrl_chk #(.DWELL_S1(DWELL_S1)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .lamp  (lamp),
  .walkOn(walkOn)
);

// File: tb/xing_ctrl_top_bench.sv
module xing_ctrl_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int D0 = 4;
  localparam int D1 = 2;
  localparam int D2 = 6;
  localparam int D3 = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       walkReqAsync = 1'b0;
  logic [1:0] lamp;
  logic       walkOn;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  chkOn  = 1'b0;

  // Reference state from the requirements.
  int  mState = 0;
  int  mCnt   = 0;
  bit  mSy1   = 1'b0;
  bit  mSy2   = 1'b0;

  xing_ctrl_top #(.DWELL_S0(D0), .DWELL_S1(D1), .DWELL_S2(D2), .DWELL_S3(D3))
    u_xing_ctrl_top (
      .clk         (clk),
      .rst         (rst),
      .walkReqAsync(walkReqAsync),
      .lamp        (lamp),
      .walkOn      (walkOn)
    );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int dwellOf(int s);
    case (s)
      0: return D0;
      1: return D1;
      2: return D2;
      default: return D3;
    endcase
  endfunction

  function automatic int stepOf(int s, bit w);
    case (s)
      0: return w ? 1 : 0;
      1: return 2;
      2: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [1:0] lampOf(int s);
    case (s)
      0: return 2'b00;
      1: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  function automatic string tagOf(int s);
    case (s)
      0: return "R4";
      1: return "R7";
      2: return "R2";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    int nxt;
    bit expired;
    if (rst) begin
      mState = 0; mCnt = 0; mSy1 = 1'b0; mSy2 = 1'b0;
    end else begin
      expired = (mCnt == dwellOf(mState) - 1);
      nxt = expired ? stepOf(mState, mSy2) : mState;
      if (nxt != mState) mCnt = 0;
      else if (!expired) mCnt = mCnt + 1;
      mState = nxt;
      mSy2 = mSy1;
      mSy1 = walkReqAsync;
    end
  end

  task automatic check(string req, logic [1:0] gotL, logic gotW,
                       logic [1:0] expL, logic expW);
    checks++;
    if (gotL !== expL || gotW !== expW) begin
      fails++;
      $display("FAIL %s: lamp=%b walk=%b expected lamp=%b walk=%b",
               req, gotL, gotW, expL, expW);
    end
  endtask

  // Continuous comparison against the reference, sampled at the falling edge.
  always @(negedge clk) begin
    if (chkOn && !rst) begin
      check(tagOf(mState), lamp, walkOn, lampOf(mState), (mState == 2));
      checks++;
      if (lamp == 2'b11 || (walkOn && lamp != 2'b10)) begin
        fails++;
        $display("FAIL R8: lamp=%b walk=%b expected legal code", lamp, walkOn);
      end
    end
  end

  task automatic doReset(int n);
    rst = 1'b1;
    repeat (n) @(negedge clk);
    check("R1", lamp, walkOn, 2'b00, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    chkOn = 1'b1;
    repeat (3) @(negedge clk);

    // R1 and R4: request held high through reset release.
    walkReqAsync = 1'b1;
    doReset(2);
    for (int i = 1; i <= D0; i++) begin
      @(negedge clk);
      if (i < D0) check("R4", lamp, walkOn, 2'b00, 1'b0);
      else        check("R4", lamp, walkOn, 2'b01, 1'b0);
    end
    walkReqAsync = 1'b0;
    while (mState != 0) @(negedge clk);

    // R3: request low for a long time keeps green.
    repeat (40) @(negedge clk);
    check("R3", lamp, walkOn, 2'b00, 1'b0);

    // R9: one-cycle request after the green dwell has expired.
    walkReqAsync = 1'b1;
    @(negedge clk);
    walkReqAsync = 1'b0;
    check("R9", lamp, walkOn, 2'b00, 1'b0);
    @(negedge clk);
    check("R9", lamp, walkOn, 2'b00, 1'b0);
    @(negedge clk);
    check("R9", lamp, walkOn, 2'b01, 1'b0);

    // R6: request raised outside green only, then dropped.
    walkReqAsync = 1'b1;
    repeat (D1 + D2 - 2) @(negedge clk);
    walkReqAsync = 1'b0;
    while (mState != 0) @(negedge clk);
    repeat (25) @(negedge clk);
    check("R6", lamp, walkOn, 2'b00, 1'b0);

    // R2: walk indicator during the crossing state.
    walkReqAsync = 1'b1;
    while (mState != 2) @(negedge clk);
    walkReqAsync = 1'b0;
    check("R2", lamp, walkOn, 2'b10, 1'b1);
    while (mState != 3) @(negedge clk);
    check("R5", lamp, walkOn, 2'b10, 1'b0);

    // Random phase with varying request density and occasional resets.
    for (int blk = 0; blk < 6; blk++) begin
      int density = (blk % 3 == 0) ? 2 : ((blk % 3 == 1) ? 8 : 30);
      for (int c = 0; c < 500; c++) begin
        walkReqAsync = (($urandom % density) == 0);
        @(negedge clk);
      end
      if (blk % 2 == 1) doReset(1 + ($urandom % 3));
    end
    walkReqAsync = 1'b0;
    repeat (30) @(negedge clk);
    check("R3", lamp, walkOn, 2'b00, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule